// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Controller

This block collects hardware interrupt lines and software exception requests, records each in a per-source pending bit, and decides which event the instruction sequencer must service next. Every source has a pending bit, an enable bit and a programmable vector word. When a source wins arbitration, the controller issues a one-cycle take pulse. The pulse carries the source number and its vector. It also carries a pipeline directive: flush for an exception, or drain for a hardware interrupt. A drain lets instructions already in flight complete.

Exceptions and interrupts share one number space. Exceptions occupy ids 0..NEXC-1 and hardware line j maps to id NEXC+j, so a lower id always means a higher priority. The serviced ids are held on a stack, so nested handlers can be tracked. Nesting can be switched on or off. A return strobe from the sequencer ends the handler on top of the stack. Software programs the block through a single write port. The port sets the enables, sets or clears pending bits, selects the sensitivity of the programmable lines, switches nesting and loads vectors.

Top module: `pirq_controller`

## Requirements
- R1: After reset no bit is pending, nothing is in service (depth 0), no take is issued, every hardware source is disabled, nesting is on and the four programmable lines are edge sensitive.
- R2: Among pending, enabled sources the lowest id wins; exception k has id k and hardware line j has id NEXC+j, so any exception outranks any hardware interrupt.
- R3: Writing op 0 loads the hardware enables from cfg_data bits NEXC..N-1 (bit set = enabled). A disabled source is never taken but its pending bit is still recorded; exceptions cannot be disabled.
- R4: A take pulse occurs on the clock edge after the winning source's pending bit becomes visible, and take_vector equals the word last written for that id with op 5 (index in cfg_idx).
- R5: With each take exactly one of take_flush and take_drain is high: flush for an exception id, drain for a hardware id; both are low without a take.
- R6: An edge-sensitive source becomes pending on a rising edge of its line after a two-flop synchronizer and is cleared when taken, so a line held high gives exactly one take.
- R7: A level-sensitive source is pending while its line is high, stays pending after a take while the line remains high, and drops its hardware-set pending bit when the line falls.
- R8: Op 3 sets the sensitivity of hardware lines 0..3 from cfg_data bits 0..3 (1 = edge, 0 = level); the other hardware lines use the fixed parameter HW_EDGE_FIXED.
- R9: With nesting on (op 4, cfg_data bit 0 = 1) a source preempts the one in service only if its id is strictly lower. The ids in service are stacked, and each rti pops the top and resumes the previous level.
- R10: With nesting off, no hardware interrupt is taken while anything is in service, but an exception with a lower id than the one in service still preempts.
- R11: Op 1 sets the pending bits given by cfg_data[N-1:0] and op 2 clears them. A software-set bit is arbitrated exactly like a hardware event.
- R12: No take is issued on a clock edge at which rti is high, and rti with nothing in service leaves the depth at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | NHW | Asynchronous hardware interrupt lines |
| exc_req | input | NEXC | Synchronous exception request strobes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Write operation: 0 enable, 1 set, 2 clear, 3 sensitivity, 4 nesting, 5 vector |
| cfg_idx | input | clog2(N) | Source id for a vector write |
| cfg_data | input | VW | Write data |
| rti | input | 1 | Return from the handler in service |
| take_valid | output | 1 | One-cycle service request to the sequencer |
| take_id | output | clog2(N) | Id of the source being taken |
| take_vector | output | VW | Vector word of that source |
| take_flush | output | 1 | Abort everything in the pipeline |
| take_drain | output | 1 | Let in-flight instructions complete |
| pending | output | N | Pending bit of every source |
| insvc_valid | output | 1 | A handler is in service |
| insvc_id | output | clog2(N) | Id on top of the in-service stack |
| depth | output | clog2(N+1) | Number of stacked handlers |

## Verification
The checks assume that exception strobes and configuration writes are synchronous to clk, that the sequencer accepts every take pulse, and that rti is only raised for a handler the sequencer actually entered. The stimulus drives every input on the falling edge and raises rti only after a take it has seen. Random pending patterns are injected mostly through software set writes and then drained one take and one return at a time. This keeps the in-service stack consistent with the bench's own arbitration model.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [2:0] {
    OP_ENABLE  = 3'd0,
    OP_SET     = 3'd1,
    OP_CLEAR   = 3'd2,
    OP_EDGESEL = 3'd3,
    OP_NEST    = 3'd4,
    OP_VECTOR  = 3'd5
  } cfg_op_e;
endpackage

// File: rtl/pirq_src_cell.sv
// One source: optional synchronizer, edge detect and the pending bit.
module pirq_src_cell #(
  parameter bit SYNC = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic edge_mode,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ack,
  output logic pend
);
  logic s_now, s_old, rise, fall, nxt;

  generate
    if (SYNC) begin : g_sync
      logic meta;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta  <= 1'b0;
          s_now <= 1'b0;
        end else begin
          meta  <= raw;
          s_now <= meta;
        end
      end
    end else begin : g_direct
      assign s_now = raw;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) s_old <= 1'b0;
    else     s_old <= s_now;
  end

  assign rise = s_now & ~s_old;
  assign fall = s_old & ~s_now;

  always_comb begin
    if (edge_mode) nxt = rise | sw_set | (pend & ~sw_clr & ~ack);
    else           nxt = s_now | sw_set | (pend & ~sw_clr & ~ack & ~fall);
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= nxt;
  end
endmodule

// File: rtl/pirq_prio.sv
// Fixed-priority pick: lowest set index wins.
module pirq_prio #(
  parameter int N = 16,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]   req,
  output logic           found,
  output logic [IDW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/pirq_stack.sv
// Stack of ids in service; the top is the current priority level.
module pirq_stack #(
  parameter int DEPTH = 16,
  parameter int IDW   = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           pop,
  input  logic [IDW-1:0] push_id,
  output logic           top_valid,
  output logic [IDW-1:0] top_id,
  output logic [DW-1:0]  level
);
  logic [IDW-1:0] mem [DEPTH];
  logic [DW-1:0]  sp;
  logic [DW-1:0]  sp_m1;

  assign sp_m1 = sp - DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && sp != DW'(DEPTH)) begin
      sp <= sp + DW'(1);
    end else if (pop && sp != '0) begin
      sp <= sp_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[sp[AW-1:0]] <= push_id;
  end

  assign top_valid = (sp != '0);
  assign top_id    = top_valid ? mem[sp_m1[AW-1:0]] : '0;
  assign level     = sp;
endmodule

// File: rtl/pirq_controller.sv
module pirq_controller #(
  parameter int          NEXC          = 4,
  parameter int          NHW           = 12,
  parameter int          NEXT          = 4,
  parameter int          VW            = 32,
  parameter logic [11:0] HW_EDGE_FIXED = 12'hFF0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NHW-1:0]                   hw_irq,
  input  logic [NEXC-1:0]                  exc_req,
  input  logic                             cfg_we,
  input  logic [2:0]                       cfg_op,
  input  logic [$clog2(NEXC+NHW)-1:0]      cfg_idx,
  input  logic [VW-1:0]                    cfg_data,
  input  logic                             rti,
  output logic                             take_valid,
  output logic [$clog2(NEXC+NHW)-1:0]      take_id,
  output logic [VW-1:0]                    take_vector,
  output logic                             take_flush,
  output logic                             take_drain,
  output logic [NEXC+NHW-1:0]              pending,
  output logic                             insvc_valid,
  output logic [$clog2(NEXC+NHW)-1:0]      insvc_id,
  output logic [$clog2(NEXC+NHW+1)-1:0]    depth
);
  import pirq_pkg::*;

  localparam int N   = NEXC + NHW;
  localparam int IDW = $clog2(N);
  localparam int DW  = $clog2(N + 1);

  cfg_op_e        op;
  logic [NHW-1:0] enable_q;
  logic [NEXT-1:0] ext_edge_q;
  logic           nest_q;
  logic [VW-1:0]  vec_mem [N];

  logic [N-1:0]   sw_set, sw_clr, ack, eligible;
  logic           found, accept, is_exc;
  logic [IDW-1:0] win;

  assign op = cfg_op_e'(cfg_op);

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q   <= '0;
      ext_edge_q <= '1;
      nest_q     <= 1'b1;
    end else if (cfg_we) begin
      case (op)
        OP_ENABLE:  enable_q   <= cfg_data[N-1:NEXC];
        OP_EDGESEL: ext_edge_q <= cfg_data[NEXT-1:0];
        OP_NEST:    nest_q     <= cfg_data[0];
        default: ;
      endcase
    end
  end

  // Vector words: write port and registered read, no reset
  always_ff @(posedge clk) begin
    if (cfg_we && op == OP_VECTOR) vec_mem[cfg_idx] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (accept) take_vector <= vec_mem[win];
  end

  assign sw_set = (cfg_we && op == OP_SET)   ? cfg_data[N-1:0] : '0;
  assign sw_clr = (cfg_we && op == OP_CLEAR) ? cfg_data[N-1:0] : '0;

  // Per-source cells
  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      if (g < NEXC) begin : g_exc
        pirq_src_cell #(.SYNC(1'b0)) u_cell (
          .clk(clk), .rst(rst), .raw(exc_req[g]), .edge_mode(1'b0),
          .sw_set(sw_set[g]), .sw_clr(sw_clr[g]), .ack(ack[g]),
          .pend(pending[g]));
      end else begin : g_hw
        logic mode;
        if (g - NEXC < NEXT) begin : g_prog
          assign mode = ext_edge_q[g-NEXC];
        end else begin : g_fixed
          assign mode = HW_EDGE_FIXED[g-NEXC];
        end
        pirq_src_cell #(.SYNC(1'b1)) u_cell (
          .clk(clk), .rst(rst), .raw(hw_irq[g-NEXC]), .edge_mode(mode),
          .sw_set(sw_set[g]), .sw_clr(sw_clr[g]), .ack(ack[g]),
          .pend(pending[g]));
      end
    end
  endgenerate

  assign eligible = pending & {enable_q, {NEXC{1'b1}}};

  pirq_prio #(.N(N)) u_prio (
    .req(eligible), .found(found), .idx(win));

  assign is_exc = (win < IDW'(NEXC));

  always_comb begin
    accept = 1'b0;
    if (found && !rti) begin
      if (!insvc_valid)                             accept = 1'b1;
      else if (win < insvc_id && (nest_q || is_exc)) accept = 1'b1;
    end
  end

  assign ack = accept ? (N'(1) << win) : '0;

  pirq_stack #(.DEPTH(N), .IDW(IDW)) u_stack (
    .clk(clk), .rst(rst), .push(accept), .pop(rti), .push_id(win),
    .top_valid(insvc_valid), .top_id(insvc_id), .level(depth));

  // Registered take interface
  always_ff @(posedge clk) begin
    if (rst) begin
      take_valid <= 1'b0;
      take_id    <= '0;
      take_flush <= 1'b0;
      take_drain <= 1'b0;
    end else begin
      take_valid <= accept;
      take_flush <= accept & is_exc;
      take_drain <= accept & ~is_exc;
      if (accept) take_id <= win;
    end
  end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int NEXC = 4,
  parameter int N    = 16,
  localparam int IDW = $clog2(N),
  localparam int DW  = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           rti,
  input logic           nest_q,
  input logic           take_valid,
  input logic [IDW-1:0] take_id,
  input logic           take_flush,
  input logic           take_drain,
  input logic [N-1:0]   pending,
  input logic           insvc_valid,
  input logic [IDW-1:0] insvc_id,
  input logic [DW-1:0]  depth
);
  logic [N-1:0] pend_d;
  always_ff @(posedge clk) begin
    if (rst) pend_d <= '0;
    else     pend_d <= pending;
  end

  // R4: a taken id was pending on the previous edge
  a_r4_taken_was_pending: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> pend_d[take_id]);

  // R5: directive matches the event class
  a_r5_flush_for_exc: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> (take_flush == (take_id < IDW'(NEXC))));

  a_r5_one_directive: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> (take_flush ^ take_drain));

  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !take_valid |-> (!take_flush && !take_drain));

  // R9: preemption only by a strictly higher priority
  a_r9_strict_preempt: assert property (@(posedge clk) disable iff (rst)
    (take_valid && $past(insvc_valid)) |-> (take_id < $past(insvc_id)));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= DW'(N));

  // R10: without nesting only exceptions preempt
  a_r10_no_hw_nesting: assert property (@(posedge clk) disable iff (rst)
    (take_valid && $past(insvc_valid) && !$past(nest_q)) |-> (take_id < IDW'(NEXC)));

  // R12: return edge never takes
  a_r12_rti_blocks: assert property (@(posedge clk) disable iff (rst)
    rti |=> !take_valid);
endmodule

bind pirq_controller pirq_checker #(.NEXC(NEXC), .N(N)) u_pirq_checker (
  .clk(clk), .rst(rst), .rti(rti), .nest_q(nest_q),
  .take_valid(take_valid), .take_id(take_id), .take_flush(take_flush),
  .take_drain(take_drain), .pending(pending), .insvc_valid(insvc_valid),
  .insvc_id(insvc_id), .depth(depth));

// File: tb/tb_pirq_controller.sv
module tb_pirq_controller;
  localparam int CLK_PERIOD = 10;
  localparam int NEXC = 4;
  localparam int NHW  = 12;
  localparam int N    = NEXC + NHW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NHW-1:0]  hw_irq = '0;
  logic [NEXC-1:0] exc_req = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_op = '0;
  logic [3:0]    cfg_idx = '0;
  logic [31:0]   cfg_data = '0;
  logic          rti = 1'b0;
  logic          take_valid, take_flush, take_drain, insvc_valid;
  logic [3:0]    take_id, insvc_id;
  logic [31:0]   take_vector;
  logic [N-1:0]  pending;
  logic [4:0]    depth;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  pirq_controller dut (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .exc_req(exc_req),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rti(rti), .take_valid(take_valid), .take_id(take_id),
    .take_vector(take_vector), .take_flush(take_flush), .take_drain(take_drain),
    .pending(pending), .insvc_valid(insvc_valid), .insvc_id(insvc_id),
    .depth(depth));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] vec_of(input int id);
    return 32'hC0DE_0000 ^ (32'(id) * 32'h0000_0111);
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int op, input int idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_op = 3'(op); cfg_idx = 4'(idx); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_rti();
    @(negedge clk); rti = 1'b1;
    @(negedge clk); rti = 1'b0;
  endtask

  // waits up to lim falling edges for a take; got=0 if none
  task automatic wait_take(input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (take_valid) begin got = 1; return; end
    end
  endtask

  task automatic expect_take(input string req, input int id);
    bit got;
    wait_take(8, got);
    chk({req, " take seen"}, 32'(got), 32'd1);
    if (got) begin
      chk({req, " take_id"}, 32'(take_id), 32'(id));
      chk({req, " vector"}, take_vector, vec_of(id));
      chk({req, " flush"}, 32'(take_flush), 32'(id < NEXC));
      chk({req, " drain"}, 32'(take_drain), 32'(id >= NEXC));
    end
  endtask

  task automatic expect_none(input string req, input int cycles);
    bit got;
    wait_take(cycles, got);
    chk({req, " no take"}, 32'(got), 32'd0);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bit got;
    logic [NHW-1:0] en;
    logic [N-1:0] setb, model;
    int w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pending", 32'(pending), 32'd0);
    chk("R1 insvc", 32'(insvc_valid), 32'd0);
    chk("R1 depth", 32'(depth), 32'd0);
    chk("R1 take", 32'(take_valid), 32'd0);
    // R1/R3: hardware disabled after reset, pending still recorded
    cfg(1, 0, 32'h0000_1000);
    chk("R3 masked recorded", 32'(pending), 32'h0000_1000);
    expect_none("R1 disabled", 4);
    cfg(2, 0, 32'h0000_FFFF);
    chk("R11 clear", 32'(pending), 32'd0);

    for (int i = 0; i < N; i++) cfg(5, i, vec_of(i));

    // R2/R3/R4/R11 random drain sequences
    for (int it = 0; it < 30; it++) begin
      en = 12'($urandom);
      cfg(0, 0, {16'd0, en, 4'd0});
      cfg(4, 0, 32'($urandom % 2));
      setb = 16'($urandom) & 16'($urandom | 32'hFFF0);
      cfg(1, 0, {16'd0, setb});
      chk("R11 set visible", 32'(pending), 32'(setb));
      model = setb;
      forever begin
        w = lowest(model & {en, 4'hF});
        if (w < 0) begin
          expect_none("R3 masked left", 3);
          break;
        end
        expect_take("R2", w);
        model[w] = 1'b0;
        do_rti();
      end
      cfg(2, 0, 32'h0000_FFFF);
    end
    chk("R12 depth after drains", 32'(depth), 32'd0);

    // R4 exact timing: take one edge after pending is visible
    cfg(0, 0, 32'h0000_FFF0);
    cfg(4, 0, 32'd1);
    cfg(1, 0, 32'h0000_0200);
    @(negedge clk);
    chk("R4 take timing", 32'(take_valid), 32'd1);
    chk("R4 vector", take_vector, vec_of(9));
    do_rti();

    // R6/R8 programmable line 0 (id 4) edge mode, held high
    cfg(3, 0, 32'h0000_000F);
    @(negedge clk); hw_irq[0] = 1'b1;
    expect_take("R6 edge", 4);
    do_rti();
    expect_none("R6 held high once", 6);
    chk("R6 cleared", 32'(pending[4]), 32'd0);
    @(negedge clk); hw_irq[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R7/R8 line 0 level mode
    cfg(3, 0, 32'h0000_000E);
    @(negedge clk); hw_irq[0] = 1'b1;
    expect_take("R7 level", 4);
    do_rti();
    expect_take("R7 level retake", 4);
    @(negedge clk); hw_irq[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 drops with line", 32'(pending[4]), 32'd0);
    do_rti();
    expect_none("R7 none after drop", 5);

    // R8 fixed edge line 8 (id 12)
    @(negedge clk); hw_irq[8] = 1'b1;
    expect_take("R8 fixed edge", 12);
    do_rti();
    expect_none("R8 fixed held", 6);
    @(negedge clk); hw_irq[8] = 1'b0;
    repeat (4) @(negedge clk);

    // R9 nesting on
    cfg(1, 0, 32'(1 << 10));
    expect_take("R9 first", 10);
    cfg(1, 0, 32'(1 << 5));
    expect_take("R9 preempt", 5);
    chk("R9 depth 2", 32'(depth), 32'd2);
    cfg(1, 0, 32'(1 << 12));
    expect_none("R9 lower blocked", 4);
    do_rti();
    chk("R9 resume id", 32'(insvc_id), 32'd10);
    chk("R9 resume depth", 32'(depth), 32'd1);
    expect_none("R9 still blocked", 4);
    do_rti();
    expect_take("R9 after return", 12);
    do_rti();
    chk("R9 empty", 32'(depth), 32'd0);

    // R10 nesting off
    cfg(4, 0, 32'd0);
    cfg(1, 0, 32'(1 << 10));
    expect_take("R10 first", 10);
    cfg(1, 0, 32'(1 << 5));
    expect_none("R10 hw blocked", 4);
    @(negedge clk); exc_req = 4'b0100;
    @(negedge clk); exc_req = 4'b0000;
    expect_take("R10 exception preempts", 2);
    do_rti();
    chk("R10 back to 10", 32'(insvc_id), 32'd10);
    expect_none("R10 blocked again", 4);

    // R12 rti held over two edges: second edge must not take
    @(negedge clk); rti = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 blocked on rti edge", 32'(take_valid), 32'd0);
    chk("R12 depth floor", 32'(depth), 32'd0);
    rti = 1'b0;
    @(negedge clk);
    chk("R12 take after release", 32'(take_valid), 32'd1);
    chk("R12 id", 32'(take_id), 32'd5);
    do_rti();

    done = 1;
    finish_up();
  end
endmodule